// File: doc/BRIEF.md
# I2C Master Transaction Sequencer

This block runs a single master transaction on an I2C bus, using a 32-bit command word to describe it. It addresses a 7-bit target, sends or receives up to 2047 data bytes, and then either releases the bus with a stop or keeps it so that the next command begins with a repeated start. It does not produce SCL or SDA itself. It sends byte-level requests (start, send byte, receive byte, stop) to a bit engine below it. It takes transmit bytes from a FIFO read port and writes received bytes to a FIFO write port.

Progress and outcome are kept in a 20-bit status word. It holds the operation, a controller state, a 3-bit abort cause and the number of bytes moved. Each finished transaction raises exactly one event pulse: done with stop, done without stop, arbitration lost, or bus error. An abort for a missing acknowledge always frees the bus with a stop before the sequencer returns to idle.

Top module: `i2c_txn_seq`

## Requirements
- R1: The command word is decoded as follows: bit 0 is the direction (0 write, 1 read), bits 7:1 the target address, bit 11 the start-byte request, bits 13:12 the address mode, bit 14 the stop enable, and bits 25:15 the byte length. A command is taken only in idle, with `enable` high and `cmd_valid` pulsed, address mode equal to 1 and the start-byte bit clear. Any other command is ignored: no engine request is made and the status word does not change.
- R2: A transaction sends these engine operations in order: start (op 0), then send byte (op 1) of `{address, direction}`, then the data operations. For a write, each data byte is a send byte taken from the transmit FIFO, in FIFO order.
- R3: In a read, every receive request (op 2) acknowledges the byte (`eng_ack_out`=1) except the last one, which is not acknowledged. Each received byte is pushed to the receive FIFO in the cycle its request completes.
- R4: When stop enable is set, a successful transaction ends with a stop request (op 3) and then one `evt_done_stop` pulse. When it is clear, no stop is requested and one `evt_done_hold` pulse is raised. At most one event pulse is high in any cycle.
- R5: While a write is waiting for a data byte and the transmit FIFO is empty, no engine request is made and the state stays in progress. A pop is always followed by a send-byte request.
- R6: A missing acknowledge after the address byte aborts with cause 0. A stop is then issued, the state becomes aborted (3), and the count is 0.
- R7: A missing acknowledge on a write data byte aborts with cause 1. A stop is then issued, and the count records only the bytes that were acknowledged.
- R8: When the engine reports lost arbitration with a completion, the sequencer aborts with cause 3, pulses `evt_arb_lost`, and issues no stop.
- R9: A bus-error pulse while busy aborts at once with cause 7 and pulses `evt_bus_err`. No stop follows, and the engine request drops.
- R10: The status word holds the operation in bits 1:0 (0 write, 1 read, 3 none since reset), the state in bits 3:2 (0 idle, 1 in progress, 2 done OK, 3 aborted), the cause in bits 6:4, the receive type in bits 8:7 (always 0), and the count in bits 19:9. Its reset value is 0x00003.
- R11: A length of zero sends only the start and the address byte, followed by a stop if enabled, and completes with count 0.
- R12: An engine request stays asserted, with its operation and byte unchanged, until the engine reports completion or a bus error occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Peripheral enable; commands are taken only when high |
| cmd_valid | input | 1 | One-cycle pulse marking a new command word |
| cmd_word | input | 32 | Packed transaction command |
| eng_req | output | 1 | Request to the bit engine |
| eng_op | output | 2 | Engine operation: 0 start, 1 send byte, 2 receive byte, 3 stop |
| eng_tx_byte | output | 8 | Byte to send for op 1 |
| eng_ack_out | output | 1 | For op 2: 1 acknowledges the received byte |
| eng_done | input | 1 | One-cycle completion of the current request |
| eng_ack_in | input | 1 | For op 1: target acknowledged (1) |
| eng_arb_lost | input | 1 | Arbitration lost, valid with `eng_done` |
| eng_bus_err | input | 1 | Unexpected start or stop seen on the bus |
| eng_rx_byte | input | 8 | Byte received by op 2, valid with `eng_done` |
| txf_empty | input | 1 | Transmit FIFO empty |
| txf_data | input | 8 | Transmit FIFO head byte |
| txf_pop | output | 1 | Remove the head of the transmit FIFO |
| rxf_push | output | 1 | Write `rxf_data` into the receive FIFO |
| rxf_data | output | 8 | Received byte |
| status_word | output | 20 | Operation, state, cause, receive type and count |
| evt_done_stop | output | 1 | Pulse: transaction finished with a stop |
| evt_done_hold | output | 1 | Pulse: transaction finished without a stop |
| evt_arb_lost | output | 1 | Pulse: arbitration lost |
| evt_bus_err | output | 1 | Pulse: bus error abort |

## Verification
The assertions assume the bit engine follows a few rules. It raises `eng_done` for a single cycle and only while `eng_req` is high. It reports `eng_arb_lost` only together with a completion. A bus error is a single-cycle pulse. `cmd_valid` arrives only when no transaction is running. The bench engine model meets these rules by design: it answers every request after one cycle with a one-cycle completion, then stays quiet for one cycle. Bus errors are injected only while a write is stalled, and each command waits until the status word has left the in-progress state.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  localparam int LEN_W  = 11;
  localparam int STAT_W = 20;

  typedef enum logic [1:0] {
    ENG_START = 2'd0,
    ENG_WRITE = 2'd1,
    ENG_READ  = 2'd2,
    ENG_STOP  = 2'd3
  } eng_op_e;

  typedef enum logic [1:0] {
    CS_IDLE  = 2'd0,
    CS_BUSY  = 2'd1,
    CS_OK    = 2'd2,
    CS_ABORT = 2'd3
  } ctl_state_e;

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_TXWAIT, S_WR, S_RD, S_STOP, S_ABSTOP
  } seq_state_e;

  localparam logic [2:0] CAUSE_ADDR_NACK = 3'd0;
  localparam logic [2:0] CAUSE_DATA_NACK = 3'd1;
  localparam logic [2:0] CAUSE_ARB_LOST  = 3'd3;
  localparam logic [2:0] CAUSE_BUS_ERR   = 3'd7;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             stop_en;
    logic [1:0]       amode;
    logic             sbyte;
    logic [6:0]       addr;
    logic             rd;
  } cmd_t;

  function automatic cmd_t unpack_cmd(input logic [31:0] w);
    cmd_t c;
    c.rd      = w[0];
    c.addr    = w[7:1];
    c.sbyte   = w[11];
    c.amode   = w[13:12];
    c.stop_en = w[14];
    c.len     = w[25:15];
    return c;
  endfunction

  function automatic logic cmd_supported(input cmd_t c);
    return (c.amode == 2'd1) && !c.sbyte;
  endfunction

  function automatic logic [7:0] addr_byte(input cmd_t c);
    return {c.addr, c.rd};
  endfunction

  function automatic logic is_last(input logic [LEN_W-1:0] cnt,
                                   input logic [LEN_W-1:0] len);
    return cnt == (len - 1'b1);
  endfunction

  function automatic logic [STAT_W-1:0] pack_status(input logic [1:0] op,
                                                    input logic [1:0] st,
                                                    input logic [2:0] cause,
                                                    input logic [LEN_W-1:0] cnt);
    return {cnt, 2'b00, cause, st, op};
  endfunction

endpackage

// File: rtl/i2c_seq_cmd_dec.sv
module i2c_seq_cmd_dec
  import i2c_seq_pkg::*;
(
  input  logic        enable,
  input  logic        cmd_valid,
  input  logic        idle,
  input  logic [31:0] cmd_word,
  output cmd_t        cmd,
  output logic        accept
);
  always_comb begin
    cmd    = unpack_cmd(cmd_word);
    accept = idle && enable && cmd_valid && cmd_supported(cmd);
  end
endmodule

// File: rtl/i2c_seq_count.sv
module i2c_seq_count
  import i2c_seq_pkg::*;
#(
  parameter int W = LEN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] len,
  output logic [W-1:0] cnt,
  output logic         last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  assign last = is_last(cnt, len);
endmodule

// File: rtl/i2c_seq_status.sv
module i2c_seq_status
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd,
  input  logic              fin_ok,
  input  logic              fin_abort,
  input  logic [2:0]        cause,
  input  logic [LEN_W-1:0]  count,
  output logic [STAT_W-1:0] status_word
);
  logic [1:0] op_q;
  ctl_state_e st_q;
  logic [2:0] cause_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= 2'b11;
      st_q    <= CS_IDLE;
      cause_q <= '0;
    end else if (start) begin
      op_q    <= {1'b0, rd};
      st_q    <= CS_BUSY;
      cause_q <= '0;
    end else if (fin_abort) begin
      st_q    <= CS_ABORT;
      cause_q <= cause;
    end else if (fin_ok) begin
      st_q    <= CS_OK;
    end
  end

  assign status_word = pack_status(op_q, st_q, cause_q, count);
endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cmd_valid,
  input  logic [31:0]       cmd_word,
  output logic              eng_req,
  output logic [1:0]        eng_op,
  output logic [7:0]        eng_tx_byte,
  output logic              eng_ack_out,
  input  logic              eng_done,
  input  logic              eng_ack_in,
  input  logic              eng_arb_lost,
  input  logic              eng_bus_err,
  input  logic [7:0]        eng_rx_byte,
  input  logic              txf_empty,
  input  logic [7:0]        txf_data,
  output logic              txf_pop,
  output logic              rxf_push,
  output logic [7:0]        rxf_data,
  output logic [STAT_W-1:0] status_word,
  output logic              evt_done_stop,
  output logic              evt_done_hold,
  output logic              evt_arb_lost,
  output logic              evt_bus_err
);
  seq_state_e       state, nxt;
  cmd_t             cmd_in, cmd_q;
  logic             accept;
  logic [7:0]       wr_byte_q;
  logic [2:0]       pend_cause_q, pend_cause_d;
  logic [LEN_W-1:0] cnt;
  logic             cnt_last;

  // named internal events
  logic ev_start, ev_ok, ev_abort, ev_stop, ev_hold, ev_arb, ev_berr, ev_inc;
  logic [2:0] ev_cause;

  i2c_seq_cmd_dec u_dec (
    .enable    (enable),
    .cmd_valid (cmd_valid),
    .idle      (state == S_IDLE),
    .cmd_word  (cmd_word),
    .cmd       (cmd_in),
    .accept    (accept)
  );

  i2c_seq_count #(.W(LEN_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (ev_start),
    .inc   (ev_inc),
    .len   (cmd_q.len),
    .cnt   (cnt),
    .last  (cnt_last)
  );

  i2c_seq_status u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (ev_start),
    .rd          (cmd_in.rd),
    .fin_ok      (ev_ok),
    .fin_abort   (ev_abort),
    .cause       (ev_cause),
    .count       (cnt),
    .status_word (status_word)
  );

  always_comb begin
    nxt          = state;
    pend_cause_d = pend_cause_q;
    ev_start = 1'b0; ev_ok  = 1'b0; ev_abort = 1'b0; ev_stop = 1'b0;
    ev_hold  = 1'b0; ev_arb = 1'b0; ev_berr  = 1'b0; ev_inc  = 1'b0;
    ev_cause = pend_cause_q;
    if (state != S_IDLE && eng_bus_err) begin
      nxt      = S_IDLE;
      ev_abort = 1'b1;
      ev_berr  = 1'b1;
      ev_cause = CAUSE_BUS_ERR;
    end else begin
      case (state)
        S_IDLE: if (accept) begin
          nxt      = S_START;
          ev_start = 1'b1;
        end
        S_START: if (eng_done) begin
          if (eng_arb_lost) begin
            nxt = S_IDLE; ev_abort = 1'b1; ev_arb = 1'b1; ev_cause = CAUSE_ARB_LOST;
          end else nxt = S_ADDR;
        end
        S_ADDR: if (eng_done) begin
          if (eng_arb_lost) begin
            nxt = S_IDLE; ev_abort = 1'b1; ev_arb = 1'b1; ev_cause = CAUSE_ARB_LOST;
          end else if (!eng_ack_in) begin
            nxt = S_ABSTOP; pend_cause_d = CAUSE_ADDR_NACK;
          end else if (cmd_q.len == '0) begin
            if (cmd_q.stop_en) nxt = S_STOP;
            else begin nxt = S_IDLE; ev_ok = 1'b1; ev_hold = 1'b1; end
          end else nxt = cmd_q.rd ? S_RD : S_TXWAIT;
        end
        S_TXWAIT: if (!txf_empty) nxt = S_WR;
        S_WR: if (eng_done) begin
          if (eng_arb_lost) begin
            nxt = S_IDLE; ev_abort = 1'b1; ev_arb = 1'b1; ev_cause = CAUSE_ARB_LOST;
          end else if (!eng_ack_in) begin
            nxt = S_ABSTOP; pend_cause_d = CAUSE_DATA_NACK;
          end else begin
            ev_inc = 1'b1;
            if (!cnt_last) nxt = S_TXWAIT;
            else if (cmd_q.stop_en) nxt = S_STOP;
            else begin nxt = S_IDLE; ev_ok = 1'b1; ev_hold = 1'b1; end
          end
        end
        S_RD: if (eng_done) begin
          if (eng_arb_lost) begin
            nxt = S_IDLE; ev_abort = 1'b1; ev_arb = 1'b1; ev_cause = CAUSE_ARB_LOST;
          end else begin
            ev_inc = 1'b1;
            if (cnt_last) begin
              if (cmd_q.stop_en) nxt = S_STOP;
              else begin nxt = S_IDLE; ev_ok = 1'b1; ev_hold = 1'b1; end
            end
          end
        end
        S_STOP: if (eng_done) begin
          nxt = S_IDLE; ev_ok = 1'b1; ev_stop = 1'b1;
        end
        S_ABSTOP: if (eng_done) begin
          nxt = S_IDLE; ev_abort = 1'b1;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      cmd_q         <= '0;
      wr_byte_q     <= '0;
      pend_cause_q  <= '0;
      evt_done_stop <= 1'b0;
      evt_done_hold <= 1'b0;
      evt_arb_lost  <= 1'b0;
      evt_bus_err   <= 1'b0;
    end else begin
      state         <= nxt;
      pend_cause_q  <= pend_cause_d;
      if (ev_start) cmd_q <= cmd_in;
      if (txf_pop)  wr_byte_q <= txf_data;
      evt_done_stop <= ev_stop;
      evt_done_hold <= ev_hold;
      evt_arb_lost  <= ev_arb;
      evt_bus_err   <= ev_berr;
    end
  end

  always_comb begin
    eng_req = 1'b1;
    eng_op  = ENG_START;
    case (state)
      S_START:          eng_op = ENG_START;
      S_ADDR, S_WR:     eng_op = ENG_WRITE;
      S_RD:             eng_op = ENG_READ;
      S_STOP, S_ABSTOP: eng_op = ENG_STOP;
      default:          eng_req = 1'b0;
    endcase
  end

  assign eng_tx_byte = (state == S_ADDR) ? addr_byte(cmd_q) : wr_byte_q;
  assign eng_ack_out = (state == S_RD) && !cnt_last;
  assign txf_pop     = (state == S_TXWAIT) && !txf_empty && !eng_bus_err;
  assign rxf_push    = (state == S_RD) && eng_done && !eng_arb_lost && !eng_bus_err;
  assign rxf_data    = eng_rx_byte;
endmodule

// File: rtl/i2c_seq_checker.sv
module i2c_seq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        eng_req,
  input logic [1:0]  eng_op,
  input logic [7:0]  eng_tx_byte,
  input logic        eng_done,
  input logic        eng_arb_lost,
  input logic        eng_bus_err,
  input logic        txf_pop,
  input logic        rxf_push,
  input logic [19:0] status_word,
  input logic        evt_done_stop,
  input logic        evt_done_hold,
  input logic        evt_arb_lost,
  input logic        evt_bus_err
);
  a_r4_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt_done_stop, evt_done_hold, evt_arb_lost, evt_bus_err}));

  a_r4_stop_precedes_done: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done_stop |-> $past(eng_req && eng_done && eng_op == 2'd3));

  a_r4_ok_state: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_done_stop || evt_done_hold) |-> status_word[3:2] == 2'd2);

  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_req && !eng_done && !eng_bus_err) |=>
      (eng_req && $stable(eng_op) && $stable(eng_tx_byte)));

  a_r5_pop_then_send: assert property (@(posedge clk) disable iff (!rst_n)
    txf_pop |=> (eng_req && eng_op == 2'd1));

  a_r3_push_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    rxf_push |-> (eng_req && eng_op == 2'd2 && eng_done));

  a_r8_arb_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt_arb_lost |-> ($past(eng_done && eng_arb_lost) && status_word[6:4] == 3'd3));

  a_r9_bus_err: assert property (@(posedge clk) disable iff (!rst_n)
    evt_bus_err |-> (status_word[6:4] == 3'd7 && status_word[3:2] == 2'd3 && !eng_req));
endmodule

bind i2c_txn_seq i2c_seq_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .eng_req       (eng_req),
  .eng_op        (eng_op),
  .eng_tx_byte   (eng_tx_byte),
  .eng_done      (eng_done),
  .eng_arb_lost  (eng_arb_lost),
  .eng_bus_err   (eng_bus_err),
  .txf_pop       (txf_pop),
  .rxf_push      (rxf_push),
  .status_word   (status_word),
  .evt_done_stop (evt_done_stop),
  .evt_done_hold (evt_done_hold),
  .evt_arb_lost  (evt_arb_lost),
  .evt_bus_err   (evt_bus_err)
);

// File: tb/i2c_txn_seq_tb_top.sv
module i2c_txn_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [31:0] cmd_word = '0;
  logic        eng_req;
  logic [1:0]  eng_op;
  logic [7:0]  eng_tx_byte;
  logic        eng_ack_out;
  logic        eng_done = 1'b0;
  logic        eng_ack_in = 1'b1;
  logic        eng_arb_lost = 1'b0;
  logic        eng_bus_err = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic        txf_empty;
  logic [7:0]  txf_data;
  logic        txf_pop;
  logic        rxf_push;
  logic [7:0]  rxf_data;
  logic [19:0] status_word;
  logic        evt_done_stop, evt_done_hold, evt_arb_lost, evt_bus_err;

  always #10 clk = ~clk;

  i2c_txn_seq dut_i (.*);

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // transmit FIFO model
  logic [7:0] tx_mem [0:63];
  int tx_idx = 0;
  int tx_avail = 0;
  logic pop_seen = 1'b0;
  assign txf_empty = (tx_idx >= tx_avail);
  assign txf_data  = tx_mem[tx_idx % 64];
  always @(posedge clk) pop_seen <= txf_pop;
  always @(negedge clk) if (pop_seen) tx_idx++;

  // receive and event monitors
  logic [7:0] rx_got[$];
  int n_stop = 0, n_hold = 0, n_arb = 0, n_berr = 0;
  always @(posedge clk) begin
    if (rxf_push) rx_got.push_back(rxf_data);
    if (evt_done_stop) n_stop++;
    if (evt_done_hold) n_hold++;
    if (evt_arb_lost)  n_arb++;
    if (evt_bus_err)   n_berr++;
  end

  // scoreboard of expected engine operations: {op, byte, ack}
  logic [10:0] exp_q[$];
  int op_idx = 0;
  int nack_at = -1;
  int arb_at  = -1;
  string cur_req = "R2";

  task automatic exp_op(input logic [1:0] op, input logic [7:0] b, input bit ack);
    exp_q.push_back({op, b, ack});
  endtask

  // bit engine model and scoreboard monitor
  always @(negedge clk) begin
    if (eng_done) begin
      eng_done     = 1'b0;
      eng_arb_lost = 1'b0;
      eng_ack_in   = 1'b1;
    end else if (eng_req && rst_n) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, cur_req, "unexpected engine op", eng_op, 0);
      end else begin
        logic [10:0] e;
        e = exp_q.pop_front();
        chk(eng_op == e[10:9], cur_req, "engine op", eng_op, e[10:9]);
        if (e[10:9] == 2'd1)
          chk(eng_tx_byte == e[8:1], cur_req, "sent byte", eng_tx_byte, e[8:1]);
        if (e[10:9] == 2'd2)
          chk(eng_ack_out == e[0], "R3", "read ack", eng_ack_out, e[0]);
      end
      eng_ack_in   = (op_idx != nack_at);
      eng_arb_lost = (op_idx == arb_at);
      eng_rx_byte  = 8'hA0 + op_idx[7:0];
      eng_done     = 1'b1;
      op_idx++;
    end
  end

  function automatic logic [31:0] mkcmd(input bit rd, input logic [6:0] a,
                                        input bit stop, input int len,
                                        input logic [1:0] am, input bit sb);
    logic [31:0] w;
    w = '0;
    w[0] = rd; w[7:1] = a; w[11] = sb; w[13:12] = am; w[14] = stop;
    w[25:15] = len[10:0];
    return w;
  endfunction

  function automatic logic [19:0] st_word(input int op, input int st,
                                          input int cause, input int cnt);
    return 20'(cnt * 512 + cause * 16 + st * 4 + op);
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk);
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_end();
    int g;
    g = 0;
    while (status_word[3:2] == 2'd1 && g < 3000) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  task automatic load_tx(input int n, input logic [7:0] first);
    for (int i = 0; i < n; i++) tx_mem[(tx_idx + i) % 64] = first + 8'(i * 17);
    tx_avail = tx_idx + n;
  endtask

  int s0, h0, a0, b0, base;

  task automatic snap();
    s0 = n_stop; h0 = n_hold; a0 = n_arb; b0 = n_berr; base = op_idx;
    nack_at = -1; arb_at = -1;
  endtask

  task automatic chk_end(input string req, input logic [19:0] st,
                         input int ds, input int dh, input int da, input int db);
    chk(status_word == st, req, "status word", status_word, st);
    chk(exp_q.size() == 0, req, "ops left over", exp_q.size(), 0);
    chk(n_stop - s0 == ds && n_hold - h0 == dh && n_arb - a0 == da && n_berr - b0 == db,
        req, "event counts", {n_stop - s0, n_hold - h0, n_arb - a0, n_berr - b0},
        {ds, dh, da, db});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset value
    chk(status_word == 20'h00003, "R10", "reset status", status_word, 20'h00003);
    chk(!eng_req && !evt_done_stop && !evt_done_hold && !evt_arb_lost && !evt_bus_err,
        "R10", "reset outputs", eng_req, 0);

    // R2 R4 write three bytes with stop
    snap(); cur_req = "R2"; load_tx(3, 8'h11);
    exp_op(0, 0, 0); exp_op(1, 8'hA4, 0);
    exp_op(1, 8'h11, 0); exp_op(1, 8'h22, 0); exp_op(1, 8'h33, 0); exp_op(3, 0, 0);
    issue(mkcmd(0, 7'h52, 1, 3, 2'd1, 0));
    wait_end();
    chk_end("R4", st_word(0, 2, 0, 3), 1, 0, 0, 0);

    // R3 R4 read four bytes, hold the bus
    snap(); cur_req = "R3"; rx_got.delete();
    exp_op(0, 0, 0); exp_op(1, 8'h23, 0);
    exp_op(2, 0, 1); exp_op(2, 0, 1); exp_op(2, 0, 1); exp_op(2, 0, 0);
    issue(mkcmd(1, 7'h11, 0, 4, 2'd1, 0));
    wait_end();
    chk_end("R4", st_word(1, 2, 0, 4), 0, 1, 0, 0);
    chk(rx_got.size() == 4, "R3", "rx count", rx_got.size(), 4);
    for (int i = 0; i < 4 && i < rx_got.size(); i++)
      chk(rx_got[i] == 8'(8'hA0 + base + 2 + i), "R3", "rx byte", rx_got[i],
          8'(8'hA0 + base + 2 + i));

    // R3 repeated start, single byte read with stop
    snap(); cur_req = "R3"; rx_got.delete();
    exp_op(0, 0, 0); exp_op(1, 8'h23, 0); exp_op(2, 0, 0); exp_op(3, 0, 0);
    issue(mkcmd(1, 7'h11, 1, 1, 2'd1, 0));
    wait_end();
    chk_end("R3", st_word(1, 2, 0, 1), 1, 0, 0, 0);
    chk(rx_got.size() == 1, "R3", "single rx", rx_got.size(), 1);

    // R6 address not acknowledged
    snap(); cur_req = "R6"; load_tx(2, 8'h40); nack_at = base + 1;
    exp_op(0, 0, 0); exp_op(1, 8'h66, 0); exp_op(3, 0, 0);
    issue(mkcmd(0, 7'h33, 1, 2, 2'd1, 0));
    wait_end();
    chk_end("R6", st_word(0, 3, 0, 0), 0, 0, 0, 0);

    // R7 second data byte not acknowledged
    snap(); cur_req = "R7"; load_tx(3, 8'h05); nack_at = base + 3;
    exp_op(0, 0, 0); exp_op(1, 8'h66, 0); exp_op(1, 8'h05, 0); exp_op(1, 8'h16, 0);
    exp_op(3, 0, 0);
    issue(mkcmd(0, 7'h33, 1, 3, 2'd1, 0));
    wait_end();
    chk_end("R7", st_word(0, 3, 1, 1), 0, 0, 0, 0);

    // R8 arbitration lost on the address byte
    snap(); cur_req = "R8"; load_tx(1, 8'h09); arb_at = base + 1;
    exp_op(0, 0, 0); exp_op(1, 8'h66, 0);
    issue(mkcmd(0, 7'h33, 1, 1, 2'd1, 0));
    wait_end();
    chk_end("R8", st_word(0, 3, 3, 0), 0, 0, 1, 0);
    chk(!eng_req, "R8", "no stop after arbitration loss", eng_req, 0);

    // R11 zero length with stop
    snap(); cur_req = "R11";
    exp_op(0, 0, 0); exp_op(1, 8'hFE, 0); exp_op(3, 0, 0);
    issue(mkcmd(0, 7'h7F, 1, 0, 2'd1, 0));
    wait_end();
    chk_end("R11", st_word(0, 2, 0, 0), 1, 0, 0, 0);

    // R1 ignored commands: disabled, wrong address mode, start byte requested
    snap(); enable = 1'b0; cur_req = "R1";
    issue(mkcmd(0, 7'h10, 1, 1, 2'd1, 0));
    repeat (10) @(negedge clk);
    chk(op_idx == base && status_word == st_word(0, 2, 0, 0), "R1", "disabled ignored",
        status_word, st_word(0, 2, 0, 0));
    enable = 1'b1;
    issue(mkcmd(1, 7'h10, 1, 1, 2'd0, 0));
    repeat (10) @(negedge clk);
    chk(op_idx == base && status_word == st_word(0, 2, 0, 0), "R1", "mode 0 ignored",
        status_word, st_word(0, 2, 0, 0));
    issue(mkcmd(1, 7'h10, 1, 1, 2'd1, 1));
    repeat (10) @(negedge clk);
    chk(op_idx == base && status_word == st_word(0, 2, 0, 0), "R1", "start byte ignored",
        status_word, st_word(0, 2, 0, 0));

    // R5 stall on empty transmit FIFO, then resume
    snap(); cur_req = "R5";
    tx_mem[tx_idx % 64] = 8'hC1; tx_mem[(tx_idx + 1) % 64] = 8'hC2;
    tx_avail = tx_idx + 1;
    exp_op(0, 0, 0); exp_op(1, 8'h40, 0); exp_op(1, 8'hC1, 0); exp_op(1, 8'hC2, 0);
    exp_op(3, 0, 0);
    issue(mkcmd(0, 7'h20, 1, 2, 2'd1, 0));
    repeat (30) @(negedge clk);
    chk(op_idx == base + 3, "R5", "ops before stall", op_idx - base, 3);
    chk(!eng_req && status_word[3:2] == 2'd1, "R5", "stalled state", status_word, 1);
    tx_avail = tx_idx + 1;
    wait_end();
    chk_end("R5", st_word(0, 2, 0, 2), 1, 0, 0, 0);

    // R9 bus error while stalled
    snap(); cur_req = "R9"; load_tx(1, 8'h77);
    exp_op(0, 0, 0); exp_op(1, 8'h40, 0); exp_op(1, 8'h77, 0);
    issue(mkcmd(0, 7'h20, 1, 2, 2'd1, 0));
    repeat (20) @(negedge clk);
    eng_bus_err = 1'b1;
    @(negedge clk);
    eng_bus_err = 1'b0;
    wait_end();
    chk_end("R9", st_word(0, 3, 7, 1), 0, 0, 0, 1);
    chk(!eng_req, "R9", "request dropped", eng_req, 0);

    done_flag = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule